// File: doc/BRIEF.md
# USB Root-Hub Port Status and Control Register

This block holds the status and control word of one root-hub port, read and written as a single 32-bit register. Software sees connection, enable, reset, link state, power, indicator and speed information in one word. Port events arriving from the rest of the controller raise sticky change flags in the same word. Those events are connect and disconnect, link transitions, over-current, warm-reset completion and configuration errors.

The word mixes several write behaviours. Some bits are plain read/write. The change flags are cleared by writing one to them. The link-state field only takes a written value when a strobe bit is set in the same write. The enable bit is cleared by writing one to it. Setting the reset bit starts a port reset that runs for a fixed, parameterised number of clock cycles. When the reset ends, hardware clears the reset bit, raises the reset-change flag and enables the port if a device is still attached. An interrupt line stays high while any change flag is set.

Top module: `usb_port_status`

## Requirements
- R1: After reset the word reads 0x000000A0: link state 5 (receiver-detect) in bits 8:5 and every other bit 0. The interrupt is low.
- R2: Bit 0 follows `dev_present` one clock later. Any change of `dev_present` sets the connect-change flag at bit 17.
- R3: A disconnect clears the enabled bit (bit 1). If the port was enabled, the disconnect also sets the enable-change flag at bit 18.
- R4: Writing 1 to bit 1 clears the enabled bit and does not set bit 18. Writing 0 to bit 1 changes nothing.
- R5: Writing 1 to bit 4 while no reset is running starts a reset. Bit 4 then reads 1 for RST_CYCLES cycles, after which it clears, bit 21 is set, and bit 1 is set only if `dev_present` is high. Starting a reset clears bit 1.
- R6: Bits 8:5 take the written value only when the same write has bit 16 set. Bit 16 always reads 0.
- R7: A pulse on `link_evt` loads `link_evt_state` into bits 8:5 and sets bit 22. If a strobed write lands in the same cycle, the event wins.
- R8: Bit 9 (power) and bits 15:14 (indicators) hold whatever the last write put there.
- R9: Bits 13:10 show `dev_speed` (registered one cycle) while a device is present and 0 otherwise. Writes to these bits have no effect. Speed codes: 1 full, 2 low, 3 high, 4 super.
- R10: Writing 1 to any of bits 23:17 clears that flag and leaves the others unchanged. A hardware set in the same cycle wins over the clear.
- R11: Pulses on `warm_rst_evt`, `ovc_evt` and `cfg_err_evt` set bits 19, 20 and 23 respectively.
- R12: `irq` is high exactly when at least one of bits 23:17 is set.
- R13: Writes to bits 0, 2, 3, 10-13 and 24-31 are ignored. Bits 2, 3 and 24-31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| dev_present | input | 1 | Device attached on the port |
| dev_speed | input | 4 | Speed ID of the attached device |
| link_evt | input | 1 | Hardware link state transition pulse |
| link_evt_state | input | 4 | New link state carried with link_evt |
| warm_rst_evt | input | 1 | Warm reset completed pulse |
| ovc_evt | input | 1 | Over-current change pulse |
| cfg_err_evt | input | 1 | Port configuration error pulse |
| irq | output | 1 | High while any change flag is set |

## Verification
The bench sweeps all 16 link codes, once without the strobe and once with it. A design that ignored the strobe would lose the held value, and one that echoed the strobe would read bit 16 high. It runs resets with the device attached and with it detached, and samples bit 4 on the last busy cycle and on the first idle cycle. An off-by-one counter, or an enable that ignores presence, shows up there. The bench writes zero and then one to the enable bit, so an ordinary read/write implementation fails. It clears each change flag on its own, and it collides a clear with a hardware set on the same cycle, which catches a clear that hits neighbouring flags or beats the event.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;
    localparam int REG_W      = 32;
    localparam int B_CONN     = 0;
    localparam int B_EN       = 1;
    localparam int B_RST      = 4;
    localparam int LINK_LO    = 5;
    localparam int LINK_W     = 4;
    localparam int B_PWR      = 9;
    localparam int SPD_LO     = 10;
    localparam int SPD_W      = 4;
    localparam int IND_LO     = 14;
    localparam int IND_W      = 2;
    localparam int B_STROBE   = 16;
    localparam int CHG_LO     = 17;
    localparam int CHG_N      = 7;

    // change flag indices, relative to CHG_LO
    localparam int F_CONN = 0;
    localparam int F_EN   = 1;
    localparam int F_WARM = 2;
    localparam int F_OVC  = 3;
    localparam int F_RST  = 4;
    localparam int F_LINK = 5;
    localparam int F_CFG  = 6;

    localparam logic [LINK_W-1:0] LINK_OFF   = 4'd4;
    localparam logic [LINK_W-1:0] LINK_RXDET = 4'd5;

    typedef struct packed {
        logic              conn;
        logic              en;
        logic [LINK_W-1:0] link;
        logic              pwr;
        logic [IND_W-1:0]  ind;
        logic [SPD_W-1:0]  spd;
    } port_state_t;
endpackage

// File: rtl/port_rst_seq.sv
module port_rst_seq #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = s_q.busy && (s_q.cnt == '0);
        if (s_q.busy) begin
            if (done) s_d.busy = 1'b0;
            else      s_d.cnt  = s_q.cnt - 1'b1;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;

    // R5
    rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

// File: rtl/port_chg_flags.sv
module port_chg_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] flags,
    output logic         any
);
    typedef struct packed {
        logic [N-1:0] f;
    } flg_t;

    flg_t s_d, s_q;

    always_comb begin
        s_d.f = (s_q.f & ~sw_clr) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags = s_q.f;
    assign any   = |s_q.f;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R10
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr[i] && !hw_set[i]) |=> !flags[i]);
        // R10
        hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> flags[i]);
    end
endmodule

// File: rtl/usb_port_status.sv
module usb_port_status
    import usb_port_pkg::*;
#(
    parameter int              RST_CYCLES = 64,
    parameter logic [LINK_W-1:0] LINK_INIT = LINK_RXDET
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              dev_present,
    input  logic [SPD_W-1:0]  dev_speed,
    input  logic              link_evt,
    input  logic [LINK_W-1:0] link_evt_state,
    input  logic              warm_rst_evt,
    input  logic              ovc_evt,
    input  logic              cfg_err_evt,
    output logic              irq
);
    port_state_t st_d, st_q;
    logic             rst_start, rst_busy, rst_done;
    logic [CHG_N-1:0] chg_set, chg_clr, chg_q;
    logic             chg_any;
    logic             unplug;

    port_rst_seq #(.CYCLES(RST_CYCLES)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rst_start),
        .busy  (rst_busy),
        .done  (rst_done)
    );

    port_chg_flags #(.N(CHG_N)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (chg_set),
        .sw_clr (chg_clr),
        .flags  (chg_q),
        .any    (chg_any)
    );

    always_comb begin
        st_d      = st_q;
        unplug    = st_q.conn && !dev_present;
        rst_start = wr_en && wr_data[B_RST] && !rst_busy;
        chg_clr   = wr_en ? wr_data[CHG_LO +: CHG_N] : '0;
        chg_set   = '0;

        st_d.conn = dev_present;
        st_d.spd  = dev_present ? dev_speed : '0;
        chg_set[F_CONN] = (dev_present != st_q.conn);

        if (wr_en) begin
            st_d.pwr = wr_data[B_PWR];
            st_d.ind = wr_data[IND_LO +: IND_W];
            if (wr_data[B_STROBE]) st_d.link = wr_data[LINK_LO +: LINK_W];
        end
        if (link_evt) begin
            st_d.link        = link_evt_state;
            chg_set[F_LINK]  = 1'b1;
        end

        if (rst_done) begin
            st_d.en         = dev_present;
            chg_set[F_RST]  = 1'b1;
        end
        if (unplug) begin
            st_d.en        = 1'b0;
            chg_set[F_EN]  = st_q.en;
        end
        if (rst_start) st_d.en = 1'b0;
        if (wr_en && wr_data[B_EN]) st_d.en = 1'b0;

        chg_set[F_WARM] = warm_rst_evt;
        chg_set[F_OVC]  = ovc_evt;
        chg_set[F_CFG]  = cfg_err_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.link <= LINK_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data                      = '0;
        rd_data[B_CONN]              = st_q.conn;
        rd_data[B_EN]                = st_q.en;
        rd_data[B_RST]               = rst_busy;
        rd_data[LINK_LO +: LINK_W]   = st_q.link;
        rd_data[B_PWR]               = st_q.pwr;
        rd_data[SPD_LO +: SPD_W]     = st_q.spd;
        rd_data[IND_LO +: IND_W]     = st_q.ind;
        rd_data[CHG_LO +: CHG_N]     = chg_q;
    end

    assign irq = chg_any;

    // R4
    en_w1_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_EN]) |=> !rd_data[B_EN]);
    // R3
    unplug_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_CONN] && !dev_present) |=> (!rd_data[B_EN] && rd_data[CHG_LO + F_CONN]));
    // R2
    conn_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_present != rd_data[B_CONN]) |=> rd_data[CHG_LO + F_CONN]);
    // R6
    link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_data[B_STROBE]) && !link_evt) |=> $stable(rd_data[LINK_LO +: LINK_W]));
    // R5
    rst_end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[B_RST]) |-> rd_data[CHG_LO + F_RST]);
endmodule

// File: tb/usb_port_status_test.sv
`timescale 1ns/1ps
module usb_port_status_test;
    localparam int RST_CYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        dev_present = 1'b0;
    logic [3:0]  dev_speed = '0;
    logic        link_evt = 1'b0;
    logic [3:0]  link_evt_state = '0;
    logic        warm_rst_evt = 1'b0;
    logic        ovc_evt = 1'b0;
    logic        cfg_err_evt = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    // expected model
    logic       e_conn = 0, e_en = 0, e_rst = 0, e_pwr = 0;
    logic [3:0] e_link = 4'd5, e_spd = 0;
    logic [1:0] e_ind = 0;
    logic [6:0] e_chg = 0;

    always #2.5 clk = ~clk;

    usb_port_status #(.RST_CYCLES(RST_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .dev_present(dev_present), .dev_speed(dev_speed),
        .link_evt(link_evt), .link_evt_state(link_evt_state),
        .warm_rst_evt(warm_rst_evt), .ovc_evt(ovc_evt),
        .cfg_err_evt(cfg_err_evt), .irq(irq)
    );

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        w[0] = e_conn; w[1] = e_en; w[4] = e_rst; w[8:5] = e_link;
        w[9] = e_pwr; w[13:10] = e_spd; w[15:14] = e_ind; w[23:17] = e_chg;
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk(tag, rd_data, exp_word());
        chk({tag, " R12 irq"}, {31'd0, irq}, {31'd0, |e_chg});
    endtask

    // base write data that keeps power and indicator bits
    function automatic logic [31:0] keep();
        logic [31:0] w = '0;
        w[9] = e_pwr; w[15:14] = e_ind;
        return w;
    endfunction

    task automatic wr(logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1
        chk("R1 reset word", rd_data, 32'h0000_00A0);
        chk_all("R1");

        // R8 sweep of power and indicators
        for (int v = 0; v < 8; v++) begin
            e_pwr = v[0]; e_ind = v[2:1];
            wr(keep());
            chk_all("R8 pwr/ind");
        end

        // R6 link sweep, without and with strobe
        for (int v = 0; v < 16; v++) begin
            logic [31:0] d;
            d = keep(); d[8:5] = v[3:0];
            wr(d);
            chk_all("R6 no strobe");
            d[16] = 1'b1;
            wr(d);
            e_link = v[3:0];
            chk_all("R6 strobe");
            chk("R6 strobe reads 0", {31'd0, rd_data[16]}, 32'd0);
        end
        wr(keep() | 32'h0001_00A0); e_link = 4'd5;

        // R13 writes to read-only/reserved bits
        wr(32'hFF00_3C0D);
        e_pwr = 0; e_ind = 0;
        chk_all("R13 ro bits");

        // R2 connect, R9 speed
        dev_speed = 4'd3; dev_present = 1'b1;
        step();
        e_conn = 1; e_spd = 3; e_chg[0] = 1;
        chk_all("R2 connect");
        // R9 write to speed ignored
        wr(32'h0000_3C00);
        chk_all("R9 speed write ignored");
        for (int s = 0; s < 16; s++) begin
            dev_speed = s[3:0]; step(); e_spd = s[3:0];
            chk_all("R9 speed sweep");
        end
        // R10 clear connect change
        wr(32'h0002_0000);
        e_chg[0] = 0;
        chk_all("R10 clear csc");

        // R5 reset with device present
        wr(32'h0000_0010);
        e_rst = 1;
        chk_all("R5 reset start");
        repeat (RST_CYC - 1) step();
        chk_all("R5 last busy cycle");
        step();
        e_rst = 0; e_en = 1; e_chg[4] = 1;
        chk_all("R5 reset end enabled");

        // R4 write 0 no effect, write 1 disables
        wr(32'h0000_0000);
        chk_all("R4 write 0");
        wr(32'h0000_0002);
        e_en = 0;
        chk_all("R4 write 1 disables");

        // re-enable, then R3 disconnect
        wr(32'h0000_0010);
        repeat (RST_CYC) step();
        e_en = 1;
        chk_all("R5 re-enable");
        dev_present = 1'b0; step();
        e_conn = 0; e_en = 0; e_spd = 0; e_chg[0] = 1; e_chg[1] = 1;
        chk_all("R3 disconnect");

        // R10 clear everything
        wr(32'h00FE_0000);
        e_chg = 0;
        chk_all("R10 clear all");

        // R5 reset while detached
        wr(32'h0000_0010);
        repeat (RST_CYC) step();
        e_chg[4] = 1;
        chk_all("R5 reset detached");

        // R11 events
        @(negedge clk); warm_rst_evt = 1; @(negedge clk); warm_rst_evt = 0;
        e_chg[2] = 1; chk_all("R11 warm");
        @(negedge clk); ovc_evt = 1; @(negedge clk); ovc_evt = 0;
        e_chg[3] = 1; chk_all("R11 ovc");
        @(negedge clk); cfg_err_evt = 1; @(negedge clk); cfg_err_evt = 0;
        e_chg[6] = 1; chk_all("R11 cfg");
        // R7 link event
        @(negedge clk); link_evt = 1; link_evt_state = 4'd3;
        @(negedge clk); link_evt = 0;
        e_link = 3; e_chg[5] = 1; chk_all("R7 link event");
        // R7 event wins over strobed write
        @(negedge clk); link_evt = 1; link_evt_state = 4'd4;
        wr_en = 1; wr_data = 32'h0001_0020 | keep();
        @(negedge clk); link_evt = 0; wr_en = 0; wr_data = '0;
        e_link = 4; chk_all("R7 event priority");

        // R10 single clears
        e_chg[0] = 1; e_chg[1] = 1;
        dev_present = 1; step(); dev_present = 0; step();
        e_chg[1] = 0; e_conn = 0;
        chk_all("R10 setup");
        for (int i = 0; i < 7; i++) begin
            wr(32'(1) << (17 + i));
            e_chg[i] = 0;
            chk_all("R10 single clear");
        end

        // R10 hardware set beats clear
        @(negedge clk); ovc_evt = 1; wr_en = 1; wr_data = 32'h0010_0000;
        @(negedge clk); ovc_evt = 0; wr_en = 0; wr_data = '0;
        e_chg[3] = 1;
        chk_all("R10 set wins");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule